// File: doc/BRIEF.md
# Authentication Command and Secret Controller

This block is the byte-level command layer of a challenge/response authentication slave. It sits behind a bus front end that has already handled bit timing, reset pulses and device addressing. That front end hands it one byte at a time and forwards read requests. The first byte after a bus reset is taken as a function command. Later bytes are arguments to that command. The controller holds the challenge register and starts an external hash engine. It then returns the engine's 160-bit result one byte per read request.

The block also keeps the persistent state of the device: a 64-bit secret, a one-way lock bit that write-protects the secret, and a bus-speed select bit. A write-type command only arms an update. The update is committed when a separate programming-pulse strobe arrives. The secret can be loaded directly from an 8-byte argument, or replaced by 64 bits of a freshly computed result.

A thermistor command puts the controller into a mode that ignores the bus completely. Only a power-cycle input brings it back to normal operation. The power-cycle input keeps the persistent bits and drops all volatile state.

Top module: `auth_cmd_ctrl`

## Requirements
- R1: After `rst_n` is released, the outputs are in this state: `secret_locked`, `overdrive`, `prog_pending`, `therm_active` and `mac_start` low, `rd_byte` = FFh, `mac_chal` zero, and `mac_secret` equal to the parameter `INIT_SECRET` (default zero). The first byte after a reset or a `bus_rst` is decoded as a command.
- R2: Command 0Ch loads the challenge from the next eight bytes. Byte i goes to `mac_chal[8i+7:8i]`, so the least significant byte comes first. Bytes after the eighth leave the challenge unchanged.
- R3: Commands 36h, 35h, 30h and 33h raise `mac_start` for exactly one cycle, in the cycle after the command byte is accepted. `mac_use_id` is 1 for 35h and 33h and 0 for 36h and 30h. `mac_chal` still shows the challenge while `mac_start` is high.
- R4: The challenge reads zero from the cycle after `mac_start` onward.
- R5: After `mac_done`, each `rd_req` returns the next result byte on `rd_byte` in the following cycle. Byte k equals `mac_result[8k+7:8k]`: word A sits in bits 31:0, B in 63:32 and so on up to E in 159:128, each word sent least significant byte first. Reads made before `mac_done`, reads beyond the 20th byte, and reads with no compute in progress return FFh.
- R6: Command 5Ah followed by eight argument bytes (least significant byte first) arms a secret load, which `prog_pulse` commits to `mac_secret`. A pulse that arrives before the eighth byte has no effect.
- R7: After 30h or 33h and `mac_done`, `prog_pulse` sets the secret to `mac_result[63:0]`, with word A in the low half and word B in the high half. A pulse before `mac_done` has no effect.
- R8: Command 6Ah followed by `prog_pulse` sets `secret_locked`. Only `rst_n` clears it. While it is set, secret loads and next-secret commits leave `mac_secret` unchanged.
- R9: Command 8Bh followed by `prog_pulse` sets `overdrive`, and 8Dh followed by `prog_pulse` clears it. `overdrive` changes only on a commit, and `pwr_cycle` keeps it, the secret and the lock.
- R10: `prog_pending` rises in the cycle after 6Ah, 8Bh or 8Dh is accepted. It stays high until `bus_rst` or `pwr_cycle`.
- R11: A `prog_pulse` with no armed write (idle, or already committed once) changes nothing. After an unknown command code, every byte and pulse is ignored until the next `bus_rst`.
- R12: The command byte `THERM_CODE` (default A5h) sets `therm_active`. In that mode bytes, pulses and `bus_rst` are ignored and reads return FFh. `pwr_cycle` clears `therm_active`, the transaction state and the challenge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state, persistent bits to parameter values |
| bus_rst | input | 1 | Bus reset seen by the front end; ends the transaction |
| pwr_cycle | input | 1 | Power-cycle event; clears volatile state, keeps persistent bits |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received command or data byte |
| rd_req | input | 1 | Host requests one byte |
| rd_byte | output | 8 | Byte returned for the last read request |
| prog_pulse | input | 1 | Programming-pulse strobe that commits an armed write |
| mac_start | output | 1 | One-cycle start of the hash engine |
| mac_use_id | output | 1 | Engine should include the device ID in the message |
| mac_secret | output | 64 | Stored secret, fed to the engine |
| mac_chal | output | 64 | Challenge register, fed to the engine |
| mac_done | input | 1 | Engine result is valid |
| mac_result | input | 160 | Engine result, word A in bits 31:0 through word E in bits 159:128 |
| secret_locked | output | 1 | Secret write protection |
| overdrive | output | 1 | Bus speed select |
| prog_pending | output | 1 | A lock or speed command is awaiting completion |
| therm_active | output | 1 | Thermistor mode; bus ignored |

## Verification
The assertions check the properties that hold on every cycle:
- `mac_start` is a single-cycle pulse, and the challenge is zero the cycle after it.
- The lock bit and the secret are frozen once the lock is set.
- The speed bit moves only on a commit event.
- `prog_pending` and thermistor mode hold until their release inputs.
- Reads return FFh whenever no result is ready.

Only the bench scenarios can show the rest: the byte ordering of the challenge and of the result stream, which 64 bits become the next secret, and that partial arguments, early pulses and unknown commands leave the persistent state untouched.

// File: rtl/auth_cmd_pkg.sv
package auth_cmd_pkg;

  localparam logic [7:0] OPC_WR_CHAL  = 8'h0C;
  localparam logic [7:0] OPC_MAC      = 8'h36;
  localparam logic [7:0] OPC_MAC_ID   = 8'h35;
  localparam logic [7:0] OPC_NEXT     = 8'h30;
  localparam logic [7:0] OPC_NEXT_ID  = 8'h33;
  localparam logic [7:0] OPC_LOAD     = 8'h5A;
  localparam logic [7:0] OPC_LOCK     = 8'h6A;
  localparam logic [7:0] OPC_SPD_SET  = 8'h8B;
  localparam logic [7:0] OPC_SPD_CLR  = 8'h8D;

  typedef enum logic [2:0] {
    ST_CMD, ST_CHAL, ST_ARG, ST_PROG, ST_MAC, ST_DEAD, ST_THERM
  } ctl_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_NEXT, OP_LOCK, OP_SPD_SET, OP_SPD_CLR
  } nv_op_e;

  typedef struct packed {
    ctl_state_e nxt;
    nv_op_e     op;
    logic       start;
    logic       use_id;
    logic       arm_chal;
    logic       arm_arg;
    logic       prog;
  } decode_t;

  function automatic decode_t decode_cmd(input logic [7:0] c, input logic [7:0] therm_code);
    decode_t d;
    d.nxt      = ST_DEAD;
    d.op       = OP_NONE;
    d.start    = 1'b0;
    d.use_id   = 1'b0;
    d.arm_chal = 1'b0;
    d.arm_arg  = 1'b0;
    d.prog     = 1'b0;
    if (c == therm_code) begin
      d.nxt = ST_THERM;
    end else begin
      case (c)
        OPC_WR_CHAL: begin d.nxt = ST_CHAL; d.arm_chal = 1'b1; end
        OPC_MAC, OPC_MAC_ID: begin
          d.nxt = ST_MAC; d.start = 1'b1; d.use_id = (c == OPC_MAC_ID);
        end
        OPC_NEXT, OPC_NEXT_ID: begin
          d.nxt = ST_MAC; d.start = 1'b1; d.op = OP_NEXT; d.use_id = (c == OPC_NEXT_ID);
        end
        OPC_LOAD:    begin d.nxt = ST_ARG;  d.arm_arg = 1'b1; d.op = OP_LOAD; end
        OPC_LOCK:    begin d.nxt = ST_PROG; d.op = OP_LOCK;    d.prog = 1'b1; end
        OPC_SPD_SET: begin d.nxt = ST_PROG; d.op = OP_SPD_SET; d.prog = 1'b1; end
        OPC_SPD_CLR: begin d.nxt = ST_PROG; d.op = OP_SPD_CLR; d.prog = 1'b1; end
        default: d.nxt = ST_DEAD;
      endcase
    end
    return d;
  endfunction

  function automatic logic secret_writable(input nv_op_e op, input logic locked);
    return ((op == OP_LOAD) || (op == OP_NEXT)) && !locked;
  endfunction

endpackage

// File: rtl/acs_byte_collect.sv
module acs_byte_collect #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 8,
  localparam int W  = BYTE_W * N_BYTES,
  localparam int CW = $clog2(N_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              arm,
  input  logic              wr,
  input  logic [BYTE_W-1:0] din,
  output logic [W-1:0]      value,
  output logic              full
);
  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(N_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      value <= '0;
    end else begin
      if (arm)
        cnt <= '0;
      else if (wr && !full)
        cnt <= cnt + CW'(1);
      if (clr)
        value <= '0;
      else if (wr && !full)
        value[int'(cnt) * BYTE_W +: BYTE_W] <= din;
    end
  end
endmodule

// File: rtl/acs_cmd_fsm.sv
module acs_cmd_fsm
  import auth_cmd_pkg::*;
#(
  parameter logic [7:0] THERM_CODE = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       pwr_cycle,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       prog_pulse,
  input  logic       mac_done,
  input  logic       chal_full,
  input  logic       arg_full,
  output logic       arm_chal,
  output logic       arm_arg,
  output logic       chal_wr,
  output logic       arg_wr,
  output logic       mac_start,
  output logic       use_id,
  output logic       mac_ready,
  output logic       prog_pending,
  output logic       commit,
  output nv_op_e     commit_op,
  output logic       therm_active
);
  ctl_state_e st;
  nv_op_e     pend_op;
  decode_t    dec;
  logic       live;
  logic       cmd_take;
  logic       op_ready;

  always_comb dec = decode_cmd(rx_byte, THERM_CODE);

  assign live     = !bus_rst && !pwr_cycle;
  assign cmd_take = rx_valid && live && (st == ST_CMD);
  assign arm_chal = cmd_take && dec.arm_chal;
  assign arm_arg  = cmd_take && dec.arm_arg;
  assign chal_wr  = rx_valid && live && (st == ST_CHAL) && !chal_full;
  assign arg_wr   = rx_valid && live && (st == ST_ARG) && !arg_full;

  always_comb begin
    case (pend_op)
      OP_LOAD:                        op_ready = (st == ST_ARG) && arg_full;
      OP_NEXT:                        op_ready = (st == ST_MAC) && mac_ready;
      OP_LOCK, OP_SPD_SET, OP_SPD_CLR: op_ready = (st == ST_PROG);
      default:                        op_ready = 1'b0;
    endcase
  end

  assign commit       = prog_pulse && live && op_ready;
  assign commit_op    = pend_op;
  assign therm_active = (st == ST_THERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_CMD;
      pend_op      <= OP_NONE;
      mac_start    <= 1'b0;
      use_id       <= 1'b0;
      mac_ready    <= 1'b0;
      prog_pending <= 1'b0;
    end else begin
      mac_start <= 1'b0;
      if (pwr_cycle || (bus_rst && st != ST_THERM)) begin
        st           <= ST_CMD;
        pend_op      <= OP_NONE;
        mac_ready    <= 1'b0;
        prog_pending <= 1'b0;
      end else if (st != ST_THERM) begin
        if (cmd_take) begin
          st      <= dec.nxt;
          pend_op <= dec.op;
          if (dec.start) begin
            mac_start <= 1'b1;
            use_id    <= dec.use_id;
            mac_ready <= 1'b0;
          end
          if (dec.prog)
            prog_pending <= 1'b1;
        end
        if (st == ST_MAC && mac_done)
          mac_ready <= 1'b1;
        if (commit)
          pend_op <= OP_NONE;
      end
    end
  end
endmodule

// File: rtl/acs_nv_store.sv
module acs_nv_store
  import auth_cmd_pkg::*;
#(
  parameter int                SECRET_W    = 64,
  parameter logic [SECRET_W-1:0] INIT_SECRET = '0,
  parameter logic              INIT_LOCK   = 1'b0,
  parameter logic              INIT_SPD    = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  nv_op_e              op,
  input  logic [SECRET_W-1:0] load_val,
  input  logic [SECRET_W-1:0] next_val,
  output logic [SECRET_W-1:0] secret,
  output logic                locked,
  output logic                speed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secret <= INIT_SECRET;
      locked <= INIT_LOCK;
      speed  <= INIT_SPD;
    end else if (commit) begin
      if (secret_writable(op, locked))
        secret <= (op == OP_NEXT) ? next_val : load_val;
      case (op)
        OP_LOCK:    locked <= 1'b1;
        OP_SPD_SET: speed  <= 1'b1;
        OP_SPD_CLR: speed  <= 1'b0;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/acs_mac_reader.sv
module acs_mac_reader #(
  parameter int BYTE_W    = 8,
  parameter int MAC_BYTES = 20,
  localparam int MW = BYTE_W * MAC_BYTES,
  localparam int IW = $clog2(MAC_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_req,
  input  logic              ready,
  input  logic [MW-1:0]     result,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [IW-1:0] idx;
  logic          have_byte;

  assign have_byte = ready && (idx < IW'(MAC_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      rd_byte <= '1;
    end else begin
      if (start)
        idx <= '0;
      else if (rd_req && have_byte)
        idx <= idx + IW'(1);
      if (rd_req)
        rd_byte <= have_byte ? result[int'(idx) * BYTE_W +: BYTE_W] : '1;
    end
  end
endmodule

// File: rtl/auth_cmd_ctrl.sv
module auth_cmd_ctrl
  import auth_cmd_pkg::*;
#(
  parameter logic [7:0] THERM_CODE = 8'hA5,
  parameter int ARG_BYTES = 8,
  parameter int MAC_BYTES = 20,
  parameter logic [8*ARG_BYTES-1:0] INIT_SECRET = '0,
  parameter logic INIT_LOCK = 1'b0,
  parameter logic INIT_SPD  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_rst,
  input  logic         pwr_cycle,
  input  logic         rx_valid,
  input  logic [7:0]   rx_byte,
  input  logic         rd_req,
  output logic [7:0]   rd_byte,
  input  logic         prog_pulse,
  output logic         mac_start,
  output logic         mac_use_id,
  output logic [63:0]  mac_secret,
  output logic [63:0]  mac_chal,
  input  logic         mac_done,
  input  logic [159:0] mac_result,
  output logic         secret_locked,
  output logic         overdrive,
  output logic         prog_pending,
  output logic         therm_active
);
  localparam int BYTE_W = 8;
  localparam int ARG_W  = BYTE_W * ARG_BYTES;

  logic            arm_chal, arm_arg, chal_wr, arg_wr;
  logic            chal_full, arg_full;
  logic            mac_ready;
  logic            commit_ev;
  nv_op_e          commit_op;
  logic [ARG_W-1:0] arg_val;
  logic            chal_clr;

  assign chal_clr = mac_start || pwr_cycle;

  acs_cmd_fsm #(.THERM_CODE(THERM_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .pwr_cycle(pwr_cycle),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .prog_pulse(prog_pulse),
    .mac_done(mac_done), .chal_full(chal_full), .arg_full(arg_full),
    .arm_chal(arm_chal), .arm_arg(arm_arg), .chal_wr(chal_wr), .arg_wr(arg_wr),
    .mac_start(mac_start), .use_id(mac_use_id), .mac_ready(mac_ready),
    .prog_pending(prog_pending), .commit(commit_ev), .commit_op(commit_op),
    .therm_active(therm_active)
  );

  acs_byte_collect #(.BYTE_W(BYTE_W), .N_BYTES(ARG_BYTES)) u_chal (
    .clk(clk), .rst_n(rst_n), .clr(chal_clr), .arm(arm_chal), .wr(chal_wr),
    .din(rx_byte), .value(mac_chal), .full(chal_full)
  );

  acs_byte_collect #(.BYTE_W(BYTE_W), .N_BYTES(ARG_BYTES)) u_arg (
    .clk(clk), .rst_n(rst_n), .clr(pwr_cycle), .arm(arm_arg), .wr(arg_wr),
    .din(rx_byte), .value(arg_val), .full(arg_full)
  );

  acs_nv_store #(
    .SECRET_W(ARG_W), .INIT_SECRET(INIT_SECRET),
    .INIT_LOCK(INIT_LOCK), .INIT_SPD(INIT_SPD)
  ) u_nv (
    .clk(clk), .rst_n(rst_n), .commit(commit_ev), .op(commit_op),
    .load_val(arg_val), .next_val(mac_result[ARG_W-1:0]),
    .secret(mac_secret), .locked(secret_locked), .speed(overdrive)
  );

  acs_mac_reader #(.BYTE_W(BYTE_W), .MAC_BYTES(MAC_BYTES)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(mac_start), .rd_req(rd_req),
    .ready(mac_ready), .result(mac_result), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/auth_cmd_ctrl_chk.sv
module auth_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rst,
  input logic        pwr_cycle,
  input logic        rd_req,
  input logic [7:0]  rd_byte,
  input logic        mac_start,
  input logic [63:0] mac_chal,
  input logic [63:0] mac_secret,
  input logic        secret_locked,
  input logic        overdrive,
  input logic        prog_pending,
  input logic        therm_active,
  input logic        commit_ev,
  input logic        mac_ready
);
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |=> !mac_start);

  a_r4_chal_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |=> (mac_chal == 64'h0));

  a_r5_blank_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !mac_ready) |=> (rd_byte == 8'hFF));

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    secret_locked |=> secret_locked);

  a_r8_secret_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    secret_locked |=> $stable(mac_secret));

  a_r9_speed_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(overdrive));

  a_r10_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pending && !bus_rst && !pwr_cycle) |=> prog_pending);

  a_r12_therm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_active && !pwr_cycle) |=> therm_active);

  a_r12_therm_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_active && rd_req) |=> (rd_byte == 8'hFF));

  a_r12_therm_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    therm_active |-> !mac_start);
endmodule

bind auth_cmd_ctrl auth_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .pwr_cycle(pwr_cycle),
  .rd_req(rd_req), .rd_byte(rd_byte), .mac_start(mac_start),
  .mac_chal(mac_chal), .mac_secret(mac_secret),
  .secret_locked(secret_locked), .overdrive(overdrive),
  .prog_pending(prog_pending), .therm_active(therm_active),
  .commit_ev(commit_ev), .mac_ready(mac_ready)
);

// File: tb/auth_cmd_ctrl_test.sv
`timescale 1ns/1ps
module auth_cmd_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_rst = 1'b0, pwr_cycle = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_byte = 8'h00;
  logic         rd_req = 1'b0;
  logic [7:0]   rd_byte;
  logic         prog_pulse = 1'b0;
  logic         mac_start, mac_use_id;
  logic [63:0]  mac_secret, mac_chal;
  logic         mac_done = 1'b0;
  logic [159:0] mac_result = '0;
  logic         secret_locked, overdrive, prog_pending, therm_active;

  int total = 0;
  int fails = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  auth_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .pwr_cycle(pwr_cycle),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req), .rd_byte(rd_byte),
    .prog_pulse(prog_pulse), .mac_start(mac_start), .mac_use_id(mac_use_id),
    .mac_secret(mac_secret), .mac_chal(mac_chal), .mac_done(mac_done),
    .mac_result(mac_result), .secret_locked(secret_locked), .overdrive(overdrive),
    .prog_pending(prog_pending), .therm_active(therm_active)
  );

  // command byte and challenge per row
  localparam logic [71:0] VEC [4] = '{
    {8'h36, 64'h0011_2233_4455_6677},
    {8'h35, 64'hFEDC_BA98_7654_3210},
    {8'h30, 64'h8000_0000_0000_0001},
    {8'h33, 64'hA5A5_5A5A_F00F_0FF0}
  };

  task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send64(input logic [63:0] v);
    for (int k = 0; k < 8; k++) send(v[8*k +: 8]);
  endtask

  task automatic breset();
    bus_rst = 1'b1; @(negedge clk); bus_rst = 1'b0;
  endtask

  task automatic ppulse();
    prog_pulse = 1'b1; @(negedge clk); prog_pulse = 1'b0;
  endtask

  task automatic pcycle();
    pwr_cycle = 1'b1; @(negedge clk); pwr_cycle = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; v = rd_byte;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] w [5];
    logic [7:0]  b;
    logic [63:0] exp_secret;
    logic [63:0] chal;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 locked", secret_locked, 0);
    check("R1 speed", overdrive, 0);
    check("R1 pending", prog_pending, 0);
    check("R1 therm", therm_active, 0);
    check("R1 secret", mac_secret, 64'h0);
    check("R1 chal", mac_chal, 64'h0);
    do_read(b);
    check("R1 idle read", b, 8'hFF);
    exp_secret = 64'h0;

    // table walk: R2 load, R3 start, R4 consume
    for (int i = 0; i < 4; i++) begin
      breset();
      send(8'h0C);
      send64(VEC[i][63:0]);
      check("R2 challenge", mac_chal, VEC[i][63:0]);
      breset();
      send(VEC[i][71:64]);
      check("R3 start", mac_start, 1);
      check("R3 use id", mac_use_id, (VEC[i][71:64] == 8'h35 || VEC[i][71:64] == 8'h33));
      check("R3 chal at start", mac_chal, VEC[i][63:0]);
      @(negedge clk);
      check("R3 single pulse", mac_start, 0);
      check("R4 cleared", mac_chal, 64'h0);
    end

    // R2 extra bytes ignored
    breset();
    send(8'h0C);
    send64(64'h1122_3344_5566_7788);
    send(8'hEE);
    check("R2 ninth byte", mac_chal, 64'h1122_3344_5566_7788);

    // R5 result stream
    for (int k = 0; k < 5; k++) w[k] = 32'h1357_9BDF * (k + 3) + 32'h0102_0304;
    mac_result = {w[4], w[3], w[2], w[1], w[0]};
    breset();
    send(8'h36);
    do_read(b);
    check("R5 read before done", b, 8'hFF);
    mac_done = 1'b1; @(negedge clk); mac_done = 1'b0;
    for (int k = 0; k < 20; k++) begin
      do_read(b);
      check("R5 mac byte", b, (w[k / 4] >> (8 * (k % 4))) & 32'hFF);
    end
    do_read(b);
    check("R5 past end", b, 8'hFF);
    breset();
    do_read(b);
    check("R5 after bus reset", b, 8'hFF);

    // R7 next secret from A/B words
    for (int k = 0; k < 5; k++) w[k] = 32'hC0DE_0000 + 32'h1111 * k;
    mac_result = {w[4], w[3], w[2], w[1], w[0]};
    breset();
    send(8'h0C);
    send64(64'h0F0E_0D0C_0B0A_0908);
    breset();
    send(8'h33);
    ppulse();
    check("R7 early pulse", mac_secret, exp_secret);
    mac_done = 1'b1; @(negedge clk); mac_done = 1'b0;
    ppulse();
    exp_secret = {w[1], w[0]};
    check("R7 next secret", mac_secret, exp_secret);

    // R6 load secret
    breset();
    send(8'h5A);
    chal = 64'hDEAD_BEEF_CAFE_F00D;
    for (int k = 0; k < 4; k++) send(chal[8*k +: 8]);
    ppulse();
    check("R6 partial arg", mac_secret, exp_secret);
    for (int k = 4; k < 8; k++) send(chal[8*k +: 8]);
    ppulse();
    exp_secret = chal;
    check("R6 load commit", mac_secret, exp_secret);

    // R11 idle pulse and unknown command
    breset();
    ppulse();
    check("R11 idle pulse secret", mac_secret, exp_secret);
    check("R11 idle pulse lock", secret_locked, 0);
    breset();
    send(8'h77);
    send(8'h0C);
    send64(64'h1234_5678_9ABC_DEF0);
    check("R11 unknown chal", mac_chal, 64'h0);
    send(8'h6A);
    ppulse();
    check("R11 unknown lock", secret_locked, 0);
    check("R11 unknown pending", prog_pending, 0);

    // R9 / R10 speed bit
    breset();
    send(8'h8B);
    check("R10 pending set", prog_pending, 1);
    check("R9 before pulse", overdrive, 0);
    ppulse();
    check("R9 set speed", overdrive, 1);
    check("R10 pending held", prog_pending, 1);
    breset();
    check("R10 pending released", prog_pending, 0);
    send(8'h8D);
    ppulse();
    check("R9 clear speed", overdrive, 0);
    breset();
    send(8'h8B);
    ppulse();
    pcycle();
    check("R9 speed kept", overdrive, 1);
    check("R10 pending pwr", prog_pending, 0);
    check("R9 secret kept", mac_secret, exp_secret);

    // R8 lock
    breset();
    send(8'h6A);
    ppulse();
    check("R8 locked", secret_locked, 1);
    breset();
    send(8'h5A);
    send64(64'h5555_AAAA_5555_AAAA);
    ppulse();
    check("R8 load blocked", mac_secret, exp_secret);
    breset();
    send(8'h30);
    mac_done = 1'b1; @(negedge clk); mac_done = 1'b0;
    ppulse();
    check("R8 next blocked", mac_secret, exp_secret);
    pcycle();
    check("R8 lock kept", secret_locked, 1);

    // R12 thermistor mode
    breset();
    send(8'h0C);
    send64(64'h0BAD_F00D_0BAD_F00D);
    breset();
    send(8'hA5);
    check("R12 therm on", therm_active, 1);
    send(8'h8D);
    ppulse();
    check("R12 pulse ignored", overdrive, 1);
    breset();
    check("R12 bus reset ignored", therm_active, 1);
    send(8'h36);
    check("R12 no start", mac_start, 0);
    do_read(b);
    check("R12 read blank", b, 8'hFF);
    pcycle();
    check("R12 therm off", therm_active, 0);
    check("R12 chal dropped", mac_chal, 64'h0);
    check("R12 lock kept", secret_locked, 1);
    check("R12 speed kept", overdrive, 1);
    breset();
    send(8'h0C);
    send64(64'h0102_0304_0506_0708);
    check("R12 normal again", mac_chal, 64'h0102_0304_0506_0708);

    finish_run();
  end
endmodule